// File: doc/BRIEF.md
# Display Character Output Port

This block lets a processor send characters to a display through two registers on a 16-bit memory-mapped bus. Software polls a status word, or enables an interrupt, to learn when the display can take another character. It then writes the character to the data register. The port passes each accepted character to the display sink with a one-cycle valid strobe. It then reports busy until the sink returns a one-cycle completion pulse.

While the port is busy, writes to the data register are dropped without any sign to software. So a program that ignores the status word loses characters but does not corrupt the one in flight. The interrupt request is the ready flag gated by a software-set enable bit.

Top module: `disp_out_port`

## Requirements
- R1: The status word is at address 0xFE04 and the data register at 0xFE06. A write to any other address changes nothing, and a read of any other address returns 0x0000.
- R2: A read returns its value on `rdata` in the cycle after `rd_en` is sampled, and `rdata` is 0x0000 in cycles after no read. The status word has bit 15 = ready, bit 14 = interrupt enable, and all other bits 0.
- R3: A data-register write while ready is 1 is accepted. In the next cycle ready is 0 and `char_data` equals the written bits [7:0].
- R4: A data-register write while ready is 0 is ignored. No strobe is issued, and `char_data` and the stored character are unchanged.
- R5: `char_valid` is high for exactly the one cycle after each accepted write and at no other time.
- R6: A `disp_done` pulse sets ready to 1 in the next cycle. If an accepted write happens in the same cycle, ready goes to 0.
- R7: A status write sets the interrupt enable from bit 14 of the written data. Bit 15 of a status write has no effect on ready.
- R8: `irq` is high exactly when ready and the interrupt enable are both 1.
- R9: After reset, ready is 1, the interrupt enable is 0, the stored character is 0x00, and `char_valid` and `irq` are 0.
- R10: A data-register read returns the last accepted character zero-extended. Bits [15:8] of a data write are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Bus address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Read strobe for the current address |
| rdata | output | 16 | Read data, one cycle after `rd_en` |
| char_valid | output | 1 | One-cycle pulse: new character on `char_data` |
| char_data | output | 8 | Last accepted character |
| disp_done | input | 1 | One-cycle pulse from the sink: ready for another character |
| irq | output | 1 | Interrupt request |

## Verification
Every registered result appears one clock after the bus cycle that causes it. This covers the strobe and character after an accepted write, the cleared or set ready flag after a write or a done pulse, the interrupt enable after a status write, and `rdata` after a read. `irq` follows those registers with no extra cycle. The bench drives inputs on the falling edge and updates its reference model at the rising edge from the inputs it drove. It then compares every output on the next falling edge, so each result is checked in the cycle it becomes due and in every later cycle.

// File: rtl/disp_pkg.sv
// Package: shared types and default constants for the display output port.
// Assumes a 16-bit bus and 8-bit characters unless overridden at the top.
package disp_pkg;

    // Register selected by the current bus address.
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_DATA   = 2'd2
    } disp_sel_e;

    localparam int          DEF_ADDR_W      = 16;
    localparam int          DEF_DATA_W      = 16;
    localparam int          DEF_CHAR_W      = 8;
    localparam logic [15:0] DEF_STATUS_ADDR = 16'hFE04;
    localparam logic [15:0] DEF_DATA_ADDR   = 16'hFE06;
    localparam int          DEF_READY_BIT   = 15;
    localparam int          DEF_IE_BIT      = 14;

endpackage

// File: rtl/disp_addr_decode.sv
// Module: disp_addr_decode
// Maps the bus address onto the register it selects.
// Assumes the two register addresses differ; all other addresses select nothing.
module disp_addr_decode
    import disp_pkg::*;
#(
    parameter int                ADDR_W      = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(DEF_STATUS_ADDR),
    parameter logic [ADDR_W-1:0] DATA_ADDR   = ADDR_W'(DEF_DATA_ADDR)
) (
    input  logic [ADDR_W-1:0] addr,
    output disp_sel_e         sel
);

    // Full-width compare against both register addresses.
    always_comb begin
        if (addr == STATUS_ADDR)    sel = SEL_STATUS;
        else if (addr == DATA_ADDR) sel = SEL_DATA;
        else                        sel = SEL_NONE;
    end

endmodule

// File: rtl/disp_status_reg.sv
// Module: disp_status_reg
// Holds the ready flag and the interrupt enable and forms the interrupt request.
// Assumes accept is only raised while ready is 1. An accept beats a done pulse
// in the same cycle, because a new character is then in flight.
module disp_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ie_wr,
    input  logic ie_wval,
    input  logic accept,
    input  logic done,
    output logic ready,
    output logic ie,
    output logic irq
);

    // Ready flag: cleared by an accepted character, set by display completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      ready <= 1'b1;
        else if (accept) ready <= 1'b0;
        else if (done)   ready <= 1'b1;
    end

    // Interrupt enable: loaded by status-register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (ie_wr) ie <= ie_wval;
    end

    // Request is level-sensitive on both flags.
    assign irq = ready & ie;

endmodule

// File: rtl/disp_char_reg.sv
// Module: disp_char_reg
// Captures each accepted character and emits a one-cycle strobe to the display.
// Assumes accept is a single-cycle qualifier formed by the top.
module disp_char_reg #(
    parameter int CHAR_W = disp_pkg::DEF_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CHAR_W-1:0] char_in,
    output logic [CHAR_W-1:0] char_q,
    output logic              strobe
);

    // Character holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)      char_q <= '0;
        else if (accept) char_q <= char_in;
    end

    // Strobe follows accept by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= accept;
    end

endmodule

// File: rtl/disp_out_port.sv
// Module: disp_out_port
// Memory-mapped display output port: status and data registers on a bus,
// character strobe toward a display sink, interrupt on ready.
// Assumes a single bus master and a sink that pulses done once per character.
module disp_out_port
    import disp_pkg::*;
#(
    parameter int                ADDR_W      = DEF_ADDR_W,
    parameter int                DATA_W      = DEF_DATA_W,
    parameter int                CHAR_W      = DEF_CHAR_W,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(DEF_STATUS_ADDR),
    parameter logic [ADDR_W-1:0] DATA_ADDR   = ADDR_W'(DEF_DATA_ADDR),
    parameter int                READY_BIT   = DEF_READY_BIT,
    parameter int                IE_BIT      = DEF_IE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data,
    input  logic              disp_done,
    output logic              irq
);

    localparam int PAD_W = DATA_W - CHAR_W;

    disp_sel_e         sel;
    logic              ready_q;
    logic              ie_q;
    logic              accept;
    logic              ie_wr;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rd_next;

    disp_addr_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .DATA_ADDR   (DATA_ADDR)
    ) i_decode (
        .addr (addr),
        .sel  (sel)
    );

    // Qualify bus writes: data only when ready, status always.
    always_comb begin
        accept = wr_en && (sel == SEL_DATA) && ready_q;
        ie_wr  = wr_en && (sel == SEL_STATUS);
    end

    disp_status_reg i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ie_wr   (ie_wr),
        .ie_wval (wdata[IE_BIT]),
        .accept  (accept),
        .done    (disp_done),
        .ready   (ready_q),
        .ie      (ie_q),
        .irq     (irq)
    );

    disp_char_reg #(
        .CHAR_W (CHAR_W)
    ) i_char (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .char_in (wdata[CHAR_W-1:0]),
        .char_q  (char_data),
        .strobe  (char_valid)
    );

    // Assemble the status word bit by bit; unused bits read as zero.
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_status
            if (b == READY_BIT) begin : g_rdy
                assign status_word[b] = ready_q;
            end else if (b == IE_BIT) begin : g_ie
                assign status_word[b] = ie_q;
            end else begin : g_zero
                assign status_word[b] = 1'b0;
            end
        end
    endgenerate

    // Read mux for the addressed register.
    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            case (sel)
                SEL_STATUS: rd_next = status_word;
                SEL_DATA:   rd_next = {{PAD_W{1'b0}}, char_data};
                default:    rd_next = '0;
            endcase
        end
    end

    // Registered read data, zero when no read was made.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end

endmodule

// File: rtl/disp_out_port_chk.sv
// Module: disp_out_port_chk
// Temporal checks on the display output port, attached by bind.
// Assumes the internal flags ready_q and ie_q of the top are visible by name.
module disp_out_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                CHAR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              disp_done,
    input logic              ready_q,
    input logic              ie_q,
    input logic              char_valid,
    input logic [CHAR_W-1:0] char_data,
    input logic              irq
);

    // R3: an accepted data write leaves the port busy.
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DATA_ADDR && ready_q) |=> !ready_q);

    // R4: a data write while busy makes no strobe and keeps the character.
    p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DATA_ADDR && !ready_q) |=> (!char_valid && $stable(char_data)));

    // R5: the strobe never lasts two cycles.
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R6: completion without a concurrent write leaves the port ready.
    p_done_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_done && !(wr_en && addr == DATA_ADDR)) |=> ready_q);

    // R8: a request implies both flags.
    p_irq_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready_q && ie_q));

endmodule

bind disp_out_port disp_out_port_chk #(
    .ADDR_W    (ADDR_W),
    .CHAR_W    (CHAR_W),
    .DATA_ADDR (DATA_ADDR)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .disp_done  (disp_done),
    .ready_q    (ready_q),
    .ie_q       (ie_q),
    .char_valid (char_valid),
    .char_data  (char_data),
    .irq        (irq)
);

// File: tb/test_disp_out_port.sv
// Bench: behavioural reference model compared with the port on every clock.
module test_disp_out_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        char_valid;
    logic [7:0]  char_data;
    logic        disp_done = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    // model state
    int m_ready = 1, m_ie = 0, m_char = 0, m_valid = 0, m_rdata = 0;

    always #5 clk = ~clk;

    disp_out_port i_disp_out_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .char_valid(char_valid), .char_data(char_data),
        .disp_done(disp_done), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: model update at the rising edge, comparison at the falling edge.
    task automatic step();
        int n_ready, n_ie, n_char, n_valid, n_rdata, acc;
        @(posedge clk);
        if (!rst_n) begin
            n_ready = 1; n_ie = 0; n_char = 0; n_valid = 0; n_rdata = 0;
        end else begin
            acc = (wr_en && addr == 16'hFE06 && m_ready) ? 1 : 0;
            n_valid = acc;
            n_char = acc ? int'(wdata[7:0]) : m_char;
            n_rdata = 0;
            if (rd_en && addr == 16'hFE04) n_rdata = (m_ready << 15) | (m_ie << 14);
            if (rd_en && addr == 16'hFE06) n_rdata = m_char;
            n_ie = (wr_en && addr == 16'hFE04) ? int'(wdata[14]) : m_ie;
            n_ready = acc ? 0 : (disp_done ? 1 : m_ready);
        end
        m_ready = n_ready; m_ie = n_ie; m_char = n_char; m_valid = n_valid; m_rdata = n_rdata;
        @(negedge clk);
        check("R5 char_valid", int'(char_valid), m_valid);
        check("R3 char_data", int'(char_data), m_char);
        check("R8 irq", int'(irq), m_ready & m_ie);
        check("R2 rdata", int'(rdata), m_rdata);
    endtask

    task automatic bus(input logic w, input logic r, input logic [15:0] a,
                       input logic [15:0] d, input logic dn);
        wr_en = w; rd_en = r; addr = a; wdata = d; disp_done = dn;
        step();
        wr_en = 0; rd_en = 0; addr = 16'h0; wdata = 16'h0; disp_done = 0;
    endtask

    initial begin
        step(); step();
        // R9: reset values
        check("R9 char_valid", int'(char_valid), 0);
        check("R9 irq", int'(irq), 0);
        check("R9 char_data", int'(char_data), 0);
        rst_n = 1'b1;
        step();
        bus(0, 1, 16'hFE04, 0, 0);                 // R2, R9: status reads 0x8000
        check("R9 status ready", int'(rdata), 16'h8000);
        bus(1, 0, 16'hFE06, 16'hAB41, 0);          // R3, R10: accept 0x41
        check("R3 char", int'(char_data), 16'h41);
        bus(0, 1, 16'hFE06, 0, 0);                 // R10: zero-extended
        check("R10 data read", int'(rdata), 16'h0041);
        bus(0, 1, 16'hFE04, 0, 0);                 // busy
        check("R3 busy status", int'(rdata), 16'h0000);
        bus(1, 0, 16'hFE06, 16'h0042, 0);          // R4: dropped
        check("R4 no strobe", int'(char_valid), 0);
        check("R4 char kept", int'(char_data), 16'h41);
        bus(0, 1, 16'hFE06, 0, 0);
        check("R4 stored char", int'(rdata), 16'h0041);
        bus(0, 0, 0, 0, 1);                        // R6: done sets ready
        bus(1, 0, 16'hFE04, 16'h4000, 0);          // R7, R8: enable interrupt
        check("R8 irq on", int'(irq), 1);
        bus(1, 0, 16'hFE06, 16'h0043, 0);          // R8: irq drops when busy
        check("R8 irq off", int'(irq), 0);
        bus(1, 0, 16'hFE04, 16'hC000, 0);          // R7: bit 15 has no effect
        bus(0, 1, 16'hFE04, 0, 0);
        check("R7 status", int'(rdata), 16'h4000);
        bus(0, 0, 0, 0, 1);
        bus(1, 1, 16'hFE06, 16'h0044, 1);          // R6: write beats done
        bus(0, 1, 16'hFE04, 0, 0);
        check("R6 write wins", int'(rdata), 16'h4000);
        bus(0, 0, 0, 0, 1);
        bus(1, 0, 16'hFE05, 16'h0055, 0);          // R1: other addresses inert
        bus(1, 0, 16'hFE08, 16'h0000, 0);
        bus(0, 1, 16'hFE00, 0, 0);
        check("R1 other read", int'(rdata), 0);
        bus(0, 1, 16'hFE04, 0, 0);
        check("R1 status untouched", int'(rdata), 16'hC000);
        for (int i = 0; i < 6; i++) begin          // R5: character stream
            bus(1, 0, 16'hFE06, 16'(16'h0160 + i), 0);
            bus(0, 0, 0, 0, 0);
            bus(0, 0, 0, 0, 1);
        end
        rst_n = 1'b0;                              // R9: reset mid-run
        step();
        rst_n = 1'b1;
        check("R9 after reset irq", int'(irq), 0);
        done_run = 1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule